// File: doc/BRIEF.md
# Framed Rate-1/2 Convolutional Encoder with Tail Flush

The block takes a serial stream of information bits and turns each frame into a fixed-length coded bitstream. One frame runs through three phases. First, each protected bit is fed into a constraint-length-5 shift history and produces two coded bits. Second, the block appends four zero bits by itself, so the history returns to the all-zero state. Third, a run of unprotected bits passes straight to the output without coding. With the default sizes, 185 protected bits and 4 tail bits give 378 coded bits, and 78 raw bits follow them, so every frame is 456 output bits long.

Input uses a valid/ready handshake: a bit is consumed on a rising edge where both are high. The output has no backpressure. A bit is presented for one cycle whenever `out_valid` is high, and `frame_done` marks the last bit of the frame. The history clears at reset and at every frame boundary, so frames encode independently. The next frame can begin as soon as the previous frame's last raw bit has been taken.

Top module: `fe_frame_enc`

## Requirements
- R1: For each protected bit b, with the four previous protected bits d1 (newest) to d4 (oldest), the block emits first b^d1^d3^d4 and then b^d3^d4. The first of the pair appears on the cycle after b is accepted.
- R2: The history is zero at the start of every frame, including the first frame after a reset that cut a frame short. A reset also restarts the frame sequence at the first protected bit.
- R3: After a protected bit is accepted, in the next cycle `in_ready` is low and `out_valid` is high. The two coded bits of that step appear on two consecutive cycles.
- R4: After the last protected bit, the block inserts four zero-input coding steps with no input. This gives 8 coded bits at output positions 370 to 377. `in_ready` stays low for exactly 9 cycles after that last accept: one for the second bit of the pair, then 8 for the tail.
- R5: The raw bits that follow the tail are output unchanged and in order, one per accepted bit, at output positions 378 to 455. Each appears on the cycle after it is accepted.
- R6: Each frame holds exactly 456 output bits: 2*(185+4)+78.
- R7: `frame_done` is high for exactly one cycle, in the same cycle as the frame's 456th output bit. In that cycle `in_ready` is already high for the first bit of the next frame.
- R8: Driving `in_valid` or `in_bit` while `in_ready` is low has no effect on the output stream.
- R9: During reset, `out_valid` and `frame_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Block can take an input bit this cycle |
| in_bit | input | 1 | Serial input bit (protected or raw, by frame phase) |
| out_valid | output | 1 | `out_bit` carries a frame bit this cycle |
| out_bit | output | 1 | Serial output bit |
| frame_done | output | 1 | High with the final bit of a frame |

## Verification
A corrupted history bit changes at least one of the next two coded bits within four protected steps, because both generators tap d3 and d4. If a stale history survives a frame boundary, the first coded pairs of the next frame change. A phase counter that is off by one moves the tail, so bits 370 to 377 differ when the last protected bit is a one. The same fault also changes the count of cycles with `in_ready` low before the first raw bit, and moves `frame_done` away from bit 455 within the same frame. Directed frames with a single one at either end make these faults visible. Random frames, with random idle cycles and junk driven while the block is not ready, cover the rest.

// File: rtl/fe_pkg.sv
package fe_pkg;

    // Frame phase of the encoder. The _A states emit the first bit of a
    // coded pair; the _B states emit the second bit that was held back.
    typedef enum logic [2:0] {
        ST_CODE_A = 3'd0,
        ST_CODE_B = 3'd1,
        ST_TAIL_A = 3'd2,
        ST_TAIL_B = 3'd3,
        ST_PLAIN  = 3'd4
    } fe_state_e;

endpackage

// File: rtl/fe_gen.sv
// One XOR generator network: parity of the taps selected by TAPS over the
// window {history, current}. Bit 0 of the window is the current bit and
// bit k is the bit delayed by k steps.
module fe_gen #(
    parameter int           K    = 5,
    parameter logic [K-1:0] TAPS = '1
) (
    input  logic [K-1:0] win,
    output logic         par
);
    always_comb begin
        par = ^(win & TAPS);
    end
endmodule

// File: rtl/fe_seq.sv
// Frame phase sequencer: protected steps, tail steps, then raw bits.
module fe_seq
    import fe_pkg::*;
#(
    parameter int INFO_BITS = 185,
    parameter int TAIL_BITS = 4,
    parameter int RAW_BITS  = 78
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    output fe_state_e st_o,
    output logic      in_ready,
    output logic      accept,
    output logic      frame_wrap
);
    localparam int MAXC = (INFO_BITS > RAW_BITS) ? INFO_BITS : RAW_BITS;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        fe_state_e     st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        in_ready   = (seq_q.st == ST_CODE_A) || (seq_q.st == ST_PLAIN);
        accept     = in_valid && in_ready;
        frame_wrap = 1'b0;
        case (seq_q.st)
            ST_CODE_A: begin
                if (accept) seq_d.st = ST_CODE_B;
            end
            ST_CODE_B: begin
                if (seq_q.cnt == CW'(INFO_BITS - 1)) begin
                    seq_d.st  = ST_TAIL_A;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.st  = ST_CODE_A;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_TAIL_A: begin
                seq_d.st = ST_TAIL_B;
            end
            ST_TAIL_B: begin
                if (seq_q.cnt == CW'(TAIL_BITS - 1)) begin
                    seq_d.st  = ST_PLAIN;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.st  = ST_TAIL_A;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_PLAIN: begin
                if (accept) begin
                    if (seq_q.cnt == CW'(RAW_BITS - 1)) begin
                        seq_d.st   = ST_CODE_A;
                        seq_d.cnt  = '0;
                        frame_wrap = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st  = ST_CODE_A;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st  <= ST_CODE_A;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_o = seq_q.st;

endmodule

// File: rtl/fe_frame_enc.sv
// Framed rate-1/2 convolutional encoder with automatic zero tail and
// uncoded trailer.
module fe_frame_enc
    import fe_pkg::*;
#(
    parameter int                        INFO_BITS      = 185,
    parameter int                        RAW_BITS       = 78,
    parameter int                        CONSTRAINT_LEN = 5,
    parameter logic [CONSTRAINT_LEN-1:0] G_FIRST        = 5'b11011,
    parameter logic [CONSTRAINT_LEN-1:0] G_SECOND       = 5'b11001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit,
    output logic frame_done
);
    localparam int K         = CONSTRAINT_LEN;
    localparam int HW        = K - 1;
    localparam int TAIL_BITS = K - 1;
    localparam int NGEN      = 2;

    typedef struct packed {
        logic [HW-1:0] hist;   // hist[0] is the newest bit
        logic          pend;   // second bit of the current pair
        logic          obit;
        logic          oval;
        logic          done;
    } enc_t;

    enc_t enc_d, enc_q;

    fe_state_e     st_w;
    logic          accept_w;
    logic          wrap_w;
    logic          shift_bit;
    logic [K-1:0]  win;
    logic [NGEN-1:0] gbits;
    logic [HW-1:0] hist_w;

    fe_seq #(
        .INFO_BITS (INFO_BITS),
        .TAIL_BITS (TAIL_BITS),
        .RAW_BITS  (RAW_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .st_o       (st_w),
        .in_ready   (in_ready),
        .accept     (accept_w),
        .frame_wrap (wrap_w)
    );

    // Tail steps feed zeros into the history.
    assign shift_bit = (st_w == ST_TAIL_A) ? 1'b0 : in_bit;
    assign win       = {enc_q.hist, shift_bit};

    generate
        for (genvar gi = 0; gi < NGEN; gi++) begin : g_net
            fe_gen #(
                .K    (K),
                .TAPS ((gi == 0) ? G_FIRST : G_SECOND)
            ) u_gen (
                .win (win),
                .par (gbits[gi])
            );
        end
    endgenerate

    always_comb begin
        enc_d      = enc_q;
        enc_d.oval = 1'b0;
        enc_d.done = 1'b0;
        case (st_w)
            ST_CODE_A, ST_TAIL_A: begin
                if ((st_w == ST_TAIL_A) || accept_w) begin
                    enc_d.obit = gbits[0];
                    enc_d.pend = gbits[1];
                    enc_d.oval = 1'b1;
                    enc_d.hist = {enc_q.hist[HW-2:0], shift_bit};
                end
            end
            ST_CODE_B, ST_TAIL_B: begin
                enc_d.obit = enc_q.pend;
                enc_d.oval = 1'b1;
            end
            ST_PLAIN: begin
                if (accept_w) begin
                    enc_d.obit = in_bit;
                    enc_d.oval = 1'b1;
                    enc_d.done = wrap_w;
                    if (wrap_w) enc_d.hist = '0;
                end
            end
            default: begin
                enc_d.hist = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_q <= '0;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign hist_w     = enc_q.hist;
    assign out_valid  = enc_q.oval;
    assign out_bit    = enc_q.obit;
    assign frame_done = enc_q.done;

endmodule

// File: rtl/fe_frame_enc_chk.sv
module fe_frame_enc_chk
    import fe_pkg::*;
#(
    parameter int INFO_BITS = 185,
    parameter int RAW_BITS  = 78,
    parameter int K         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_bit,
    input logic          out_valid,
    input logic          out_bit,
    input logic          frame_done,
    input fe_state_e     st,
    input logic [K-2:0]  hist
);
    localparam int FRAME_OUT = 2 * (INFO_BITS + K - 1) + RAW_BITS;
    localparam int CW        = $clog2(FRAME_OUT + 1);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          seen_q <= '0;
        else if (frame_done) seen_q <= '0;
        else if (out_valid)  seen_q <= seen_q + 1'b1;
    end

    a_r3_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st == ST_CODE_A) |=> (out_valid && !in_ready) ##1 out_valid);

    a_r4_tail_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PLAIN && $past(st) == ST_TAIL_B) |-> (hist == '0));

    a_r5_raw_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st == ST_PLAIN) |=> (out_valid && out_bit == $past(in_bit)));

    a_r6_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (out_valid && seen_q == CW'(FRAME_OUT - 1)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r7_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> in_ready);

endmodule

bind fe_frame_enc fe_frame_enc_chk #(
    .INFO_BITS (INFO_BITS),
    .RAW_BITS  (RAW_BITS),
    .K         (CONSTRAINT_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_bit     (in_bit),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .frame_done (frame_done),
    .st         (st_w),
    .hist       (hist_w)
);

// File: tb/tb_fe_frame_enc.sv
module tb_fe_frame_enc;
    localparam int INFO = 185;
    localparam int RAW  = 78;
    localparam int TL   = 4;
    localparam int NOUT = 2 * (INFO + TL) + RAW;
    localparam int CODED_END = 2 * INFO;     // first tail bit position
    localparam int RAW_START = 2 * (INFO + TL);

    logic clk = 1'b0;
    logic rst_n, in_valid, in_bit;
    logic in_ready, out_valid, out_bit, frame_done;

    always #10 clk = ~clk;

    fe_frame_enc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_bit     (in_bit),
        .out_valid  (out_valid),
        .out_bit    (out_bit),
        .frame_done (frame_done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic got_q[$];
    int   done_idx[$];
    logic ready_at_done[$];
    logic info_v[INFO];
    logic raw_v[RAW];
    logic exp_v[NOUT];
    int   r3_bad;
    int   tail_wait;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) got_q.push_back(out_bit);
            if (frame_done) begin
                done_idx.push_back(got_q.size() - 1);
                ready_at_done.push_back(in_ready);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic void build_expected();
        logic [3:0] m;
        int idx;
        logic b;
        m = 4'b0;
        idx = 0;
        for (int i = 0; i < INFO + TL; i++) begin
            b = (i < INFO) ? info_v[i] : 1'b0;
            exp_v[idx]     = b ^ m[0] ^ m[2] ^ m[3];
            exp_v[idx + 1] = b ^ m[2] ^ m[3];
            idx += 2;
            m = {m[2:0], b};
        end
        for (int j = 0; j < RAW; j++) exp_v[RAW_START + j] = raw_v[j];
    endfunction

    function automatic int mismatches(input int lo, input int hi);
        int n;
        n = 0;
        for (int i = lo; i < hi; i++) begin
            if (i >= got_q.size()) n++;
            else if (got_q[i] !== exp_v[i]) n++;
        end
        return n;
    endfunction

    task automatic send(input logic b, input bit allow_gap, input bit is_coded,
                        output int waits);
        waits = 0;
        @(negedge clk);
        if (allow_gap && ($urandom % 4 == 0)) begin
            in_valid = 1'b0;
            in_bit   = 1'($urandom % 2);
            @(negedge clk);
        end
        while (!in_ready) begin
            in_valid = 1'($urandom % 2);   // junk while not ready (R8)
            in_bit   = 1'($urandom % 2);
            waits++;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_bit   = b;
        @(posedge clk);
        if (is_coded) begin
            @(negedge clk);
            if (!(out_valid && !in_ready)) r3_bad++;
        end
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < INFO; i++) begin
            case (mode)
                0:       info_v[i] = 1'b0;
                1:       info_v[i] = 1'b1;
                2:       info_v[i] = (i == 0);
                3:       info_v[i] = (i == INFO - 1);
                default: info_v[i] = 1'($urandom % 2);
            endcase
        end
        for (int j = 0; j < RAW; j++) begin
            case (mode)
                0:       raw_v[j] = 1'b0;
                1:       raw_v[j] = 1'b1;
                default: raw_v[j] = 1'($urandom % 2);
            endcase
        end
    endtask

    task automatic run_frame(input int mode, input string tag);
        int w;
        fill(mode);
        build_expected();
        got_q.delete();
        done_idx.delete();
        ready_at_done.delete();
        r3_bad = 0;
        tail_wait = -1;
        for (int i = 0; i < INFO; i++) send(info_v[i], 1'b1, 1'b1, w);
        for (int j = 0; j < RAW; j++) begin
            send(raw_v[j], j != 0, 1'b0, w);
            if (j == 0) tail_wait = w;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);

        chk(got_q.size() == NOUT, "R6", "frame length", got_q.size(), NOUT);
        chk(mismatches(0, CODED_END) == 0, "R1", "coded bits wrong",
            mismatches(0, CODED_END), 0);
        chk(mismatches(CODED_END, RAW_START) == 0, "R4", "tail bits wrong",
            mismatches(CODED_END, RAW_START), 0);
        chk(tail_wait == 2 * TL, "R4", "not-ready cycles before raw",
            tail_wait, 2 * TL);
        chk(mismatches(RAW_START, NOUT) == 0, "R5", "raw bits wrong",
            mismatches(RAW_START, NOUT), 0);
        chk(r3_bad == 0, "R3", "pair timing errors", r3_bad, 0);
        chk(done_idx.size() == 1, "R7", "done pulses", done_idx.size(), 1);
        if (done_idx.size() >= 1) begin
            chk(done_idx[0] == NOUT - 1, "R7", "done position", done_idx[0], NOUT - 1);
            chk(ready_at_done[0] == 1'b1, "R7", "ready at done", ready_at_done[0], 1);
        end
        chk(mismatches(0, NOUT) == 0, tag, "whole frame with junk while busy",
            mismatches(0, NOUT), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        void'($urandom(32'd7177));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_bit   = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        chk(frame_done == 1'b0, "R9", "frame_done in reset", frame_done, 0);
        chk(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;

        run_frame(0, "R8");
        run_frame(1, "R8");
        run_frame(2, "R8");
        run_frame(3, "R8");
        run_frame(4, "R8");

        // Cut a frame of ones short with a reset, then expect a clean frame.
        for (int i = 0; i < 50; i++) send(1'b1, 1'b0, 1'b1, w);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", "mid-frame reset state",
            {out_valid, in_ready}, 1);
        rst_n = 1'b1;
        run_frame(3, "R2");

        run_frame(5, "R8");
        run_frame(6, "R8");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule